// File: doc/BRIEF.md
# Dot clock PLL parameter search

This block works out the programming values for a pixel clock synthesizer driven by a fixed 14,318,180 Hz reference. A request carries a wanted output frequency in Hz. The block doubles that frequency until it reaches the oscillator's working band, at or above 100 MHz. Each doubling adds one step to the post-divider field. The block then tries every reference divider n from 3 to 257 in turn. For each n it derives the feedback multiplier m as the truncated quotient n·target/reference, and it keeps the pair with the smallest absolute frequency error. A result with m up to 1028 is still usable, because the oscillator loop can divide by four. In that case the error is judged on m with its two low bits cleared.

The handshake is start/busy/done. A request outside 3.125 MHz to 220 MHz (both ends legal) is turned away at once with a range-error flag, and no new codes are produced. The state machine has six states:

- S_IDLE: waits for start. It goes to S_SCALE on an in-band start. On an out-of-band start it stays in S_IDLE and reports the rejection.
- S_SCALE: doubles the target until it is at or above 100 MHz, then goes to S_LAUNCH.
- S_LAUNCH: starts the divider for the current n and goes to S_WAIT.
- S_WAIT: stays until the divider signals completion, then goes to S_EVAL.
- S_EVAL: judges the candidate. It goes back to S_LAUNCH for the next n, or to S_FINISH after n = 257.
- S_FINISH: encodes the winner, pulses done and returns to S_IDLE.

Top module: `pll_param_search`

## Requirements
- R1: After reset, busy, done and range_err are 0 and m_code, n_code and div_code are 0.
- R2: A start in idle with freq_hz below 3,125,000 or above 220,000,000 gives done and range_err high one edge after the accepting edge. busy stays low, and m_code, n_code and div_code keep their previous values.
- R3: The target is doubled while it is below 100,000,000. Bits 7:4 of div_code hold the number of doublings (each doubling adds 0x10).
- R4: n runs from 3 to 257 inclusive. The candidate multiplier is m = floor(n·target / 14,318,180), computed with the doubled target.
- R5: For m in 3..257 the error is |target·n − 14,318,180·m|. A candidate replaces the best only if its error is strictly smaller, so the lowest n wins a tie.
- R6: For m in 258..1028 the error uses m with bits 1:0 cleared. Candidates with m above 1028 are skipped.
- R7: n_code = n − 2. If the winning m is above 257, m_code = (m >> 2) − 2 and div_code bit 2 is 0. Otherwise m_code = m − 2 and div_code bit 2 is 1. div_code bits 3, 1 and 0 are always 0.
- R8: For an in-band request, busy is high from the accepting edge until done. done is a one-cycle pulse that rises k + 3827 edges after the accepting edge, where k is the number of doublings. range_err is 0 with that done.
- R9: A start while busy is ignored. The search and its result follow the first request, with unchanged latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Request strobe, taken only when idle |
| freq_hz | input | 32 | Requested pixel clock in Hz |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion pulse |
| range_err | output | 1 | Last request was out of band |
| m_code | output | 8 | Encoded feedback multiplier |
| n_code | output | 8 | Encoded reference divider |
| div_code | output | 8 | Post-divider and loop-divide field |

## Verification
A rejection is due on the very edge after the accepting edge. A search finishes exactly k + 3827 edges later: k+1 scaling cycles, fifteen cycles for each of the 255 divider values, and one encode cycle. The bench counts falling edges from the accepting edge until done is seen and compares that count with the figure derived from its own doubling count. It then reads the codes at that same falling edge, when done is visible, and confirms on the next falling edge that done has dropped. It also raises a second start on the 200th cycle of one search and checks that busy is still high at that moment. The result and latency must then match the first request.

// File: rtl/pll_search_pkg.sv
package pll_search_pkg;
    localparam int unsigned FREQ_W = 32;
    localparam int unsigned ERR_W  = 64;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SCALE,
        S_LAUNCH,
        S_WAIT,
        S_EVAL,
        S_FINISH
    } srch_state_t;
endpackage

// File: rtl/pll_band_check.sv
module pll_band_check #(
    parameter int unsigned FW    = 32,
    parameter int unsigned LO_HZ = 3125000,
    parameter int unsigned HI_HZ = 220000000
) (
    input  logic [FW-1:0] freq,
    output logic          out_of_band
);
    assign out_of_band = (freq < FW'(LO_HZ)) || (freq > FW'(HI_HZ));
endmodule

// File: rtl/pll_quot_div.sv
module pll_quot_div #(
    parameter int unsigned DW    = 41,
    parameter int unsigned DEN_W = 32,
    parameter int unsigned QW    = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [DW-1:0]    dividend,
    input  logic [DEN_W-1:0] divisor,
    output logic [QW-1:0]    quot,
    output logic [DEN_W-1:0] rem,
    output logic             fin
);
    localparam int unsigned CW = $clog2(QW + 1);

    logic [DEN_W-1:0] acc_q;
    logic [QW-1:0]    low_q;
    logic [QW-1:0]    q_q;
    logic [CW-1:0]    cnt_q;
    logic             fin_q;
    logic [DEN_W:0]   trial;
    logic             take;

    always_comb begin
        trial = {acc_q, low_q[QW-1]};
        take  = trial >= {1'b0, divisor};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
            low_q <= '0;
            q_q   <= '0;
            cnt_q <= '0;
            fin_q <= 1'b0;
        end else begin
            fin_q <= 1'b0;
            if (go) begin
                acc_q <= DEN_W'(dividend[DW-1:QW]);
                low_q <= dividend[QW-1:0];
                q_q   <= '0;
                cnt_q <= CW'(QW);
            end else if (cnt_q != '0) begin
                acc_q <= take ? DEN_W'(trial - {1'b0, divisor}) : DEN_W'(trial);
                q_q   <= {q_q[QW-2:0], take};
                low_q <= {low_q[QW-2:0], 1'b0};
                cnt_q <= cnt_q - CW'(1);
                if (cnt_q == CW'(1)) fin_q <= 1'b1;
            end
        end
    end

    assign quot = q_q;
    assign rem  = acc_q;
    assign fin  = fin_q;

    // R4: the quotient must fit QW bits for the truncated m to be exact
    p_quot_fits_r4: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> (DEN_W'(dividend[DW-1:QW]) < divisor));

    // R4: a finished division leaves a remainder below the divisor
    p_rem_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fin_q |-> (acc_q < divisor));
endmodule

// File: rtl/pll_cand_eval.sv
module pll_cand_eval #(
    parameter int unsigned FW             = 32,
    parameter int unsigned NW             = 9,
    parameter int unsigned QW             = 12,
    parameter int unsigned EW             = 64,
    parameter int unsigned REF_HZ         = 14318180,
    parameter int unsigned M_MIN          = 3,
    parameter int unsigned M_DIRECT_MAX   = 257,
    parameter int unsigned M_FALLBACK_MAX = 1028
) (
    input  logic [FW-1:0] target,
    input  logic [NW-1:0] n,
    input  logic [QW-1:0] m,
    output logic          usable,
    output logic [EW-1:0] err
);
    logic [QW-1:0] m_eff;
    logic [EW-1:0] lhs;
    logic [EW-1:0] rhs;

    always_comb begin
        if (m >= QW'(M_MIN) && m <= QW'(M_DIRECT_MAX)) m_eff = m;
        else                                          m_eff = m & ~QW'(3);
        lhs    = EW'(target) * EW'(n);
        rhs    = EW'(REF_HZ) * EW'(m_eff);
        err    = (lhs >= rhs) ? (lhs - rhs) : (rhs - lhs);
        usable = (m <= QW'(M_FALLBACK_MAX));
    end
endmodule

// File: rtl/pll_param_search.sv
module pll_param_search
    import pll_search_pkg::*;
#(
    parameter int unsigned REF_HZ         = 14318180,
    parameter int unsigned LO_HZ          = 3125000,
    parameter int unsigned HI_HZ          = 220000000,
    parameter int unsigned VCO_MIN_HZ     = 100000000,
    parameter int unsigned N_FIRST        = 3,
    parameter int unsigned N_LAST         = 257,
    parameter int unsigned M_MIN          = 3,
    parameter int unsigned M_DIRECT_MAX   = 257,
    parameter int unsigned M_FALLBACK_MAX = 1028,
    parameter int unsigned QBITS          = 12,
    parameter int unsigned CODE_W         = 8,
    parameter int unsigned DIV_STEP       = 16,
    parameter int unsigned LOOP1_BIT      = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [31:0]       freq_hz,
    output logic              busy,
    output logic              done,
    output logic              range_err,
    output logic [CODE_W-1:0] m_code,
    output logic [CODE_W-1:0] n_code,
    output logic [CODE_W-1:0] div_code
);
    localparam int unsigned NW = $clog2(N_LAST + 1);
    localparam int unsigned DW = FREQ_W + NW;

    srch_state_t       state_q, state_d;
    logic [FREQ_W-1:0] target_q;
    logic [CODE_W-1:0] div_acc_q;
    logic [NW-1:0]     n_q, best_n_q;
    logic [QBITS-1:0]  best_m_q;
    logic [ERR_W-1:0]  best_err_q;
    logic              busy_q, done_q, range_err_q;
    logic [CODE_W-1:0] m_code_q, n_code_q, div_code_q;

    logic              oob;
    logic              div_go, div_fin;
    logic [DW-1:0]     dividend;
    logic [QBITS-1:0]  quot;
    logic [FREQ_W-1:0] rem;
    logic              cand_ok;
    logic [ERR_W-1:0]  cand_err;

    pll_band_check #(.FW(FREQ_W), .LO_HZ(LO_HZ), .HI_HZ(HI_HZ)) u_band (
        .freq        (freq_hz),
        .out_of_band (oob)
    );

    assign div_go   = (state_q == S_LAUNCH);
    assign dividend = DW'(target_q) * DW'(n_q);

    pll_quot_div #(.DW(DW), .DEN_W(FREQ_W), .QW(QBITS)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (div_go),
        .dividend (dividend),
        .divisor  (FREQ_W'(REF_HZ)),
        .quot     (quot),
        .rem      (rem),
        .fin      (div_fin)
    );

    pll_cand_eval #(
        .FW(FREQ_W), .NW(NW), .QW(QBITS), .EW(ERR_W), .REF_HZ(REF_HZ),
        .M_MIN(M_MIN), .M_DIRECT_MAX(M_DIRECT_MAX), .M_FALLBACK_MAX(M_FALLBACK_MAX)
    ) u_eval (
        .target (target_q),
        .n      (n_q),
        .m      (quot),
        .usable (cand_ok),
        .err    (cand_err)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (start && !oob) state_d = S_SCALE;
            S_SCALE:  if (target_q >= FREQ_W'(VCO_MIN_HZ)) state_d = S_LAUNCH;
            S_LAUNCH: state_d = S_WAIT;
            S_WAIT:   if (div_fin) state_d = S_EVAL;
            S_EVAL:   state_d = (n_q == NW'(N_LAST)) ? S_FINISH : S_LAUNCH;
            S_FINISH: state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            target_q    <= '0;
            div_acc_q   <= '0;
            n_q         <= '0;
            best_n_q    <= '0;
            best_m_q    <= '0;
            best_err_q  <= '1;
            busy_q      <= 1'b0;
            done_q      <= 1'b0;
            range_err_q <= 1'b0;
            m_code_q    <= '0;
            n_code_q    <= '0;
            div_code_q  <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                S_IDLE: begin
                    if (start) begin
                        if (oob) begin
                            done_q      <= 1'b1;
                            range_err_q <= 1'b1;
                        end else begin
                            busy_q     <= 1'b1;
                            target_q   <= freq_hz;
                            div_acc_q  <= '0;
                            n_q        <= NW'(N_FIRST);
                            best_err_q <= '1;
                            best_m_q   <= '0;
                            best_n_q   <= '0;
                        end
                    end
                end
                S_SCALE: begin
                    if (target_q < FREQ_W'(VCO_MIN_HZ)) begin
                        target_q  <= target_q << 1;
                        div_acc_q <= div_acc_q + CODE_W'(DIV_STEP);
                    end
                end
                S_LAUNCH, S_WAIT: ;
                S_EVAL: begin
                    if (cand_ok && cand_err < best_err_q) begin
                        best_err_q <= cand_err;
                        best_m_q   <= quot;
                        best_n_q   <= n_q;
                    end
                    n_q <= n_q + NW'(1);
                end
                S_FINISH: begin
                    busy_q      <= 1'b0;
                    done_q      <= 1'b1;
                    range_err_q <= 1'b0;
                    n_code_q    <= CODE_W'(best_n_q - NW'(2));
                    if (best_m_q > QBITS'(M_DIRECT_MAX)) begin
                        m_code_q   <= CODE_W'((best_m_q >> 2) - QBITS'(2));
                        div_code_q <= div_acc_q;
                    end else begin
                        m_code_q   <= CODE_W'(best_m_q - QBITS'(2));
                        div_code_q <= div_acc_q | CODE_W'(1 << LOOP1_BIT);
                    end
                end
                default: ;
            endcase
        end
    end

    assign busy      = busy_q;
    assign done      = done_q;
    assign range_err = range_err_q;
    assign m_code    = m_code_q;
    assign n_code    = n_code_q;
    assign div_code  = div_code_q;

    // R2: out-of-band request answered on the next edge without a search
    p_reject_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && start && oob) |=> (done_q && range_err_q && !busy_q));

    // R3: the sweep only ever sees a target inside the oscillator band
    p_target_band_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_LAUNCH) |-> (target_q >= FREQ_W'(VCO_MIN_HZ) && target_q <= FREQ_W'(HI_HZ)));

    // R4: candidates are judged only for n inside the sweep window
    p_n_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_EVAL) |-> (n_q >= NW'(N_FIRST) && n_q <= NW'(N_LAST)));

    // R5: the kept error never grows during a sweep
    p_best_monotone_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_EVAL) |=> (best_err_q <= $past(best_err_q)));

    // R7: only the loop-divide bit may be set in the low nibble
    p_div_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && !range_err_q) |-> (div_code_q[1:0] == 2'b00 && !div_code_q[3]));

    // R8: done lasts a single cycle
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

    // R9: a start during a search leaves the working target untouched
    p_ignore_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (start && (state_q == S_LAUNCH || state_q == S_WAIT || state_q == S_EVAL)) |=> $stable(target_q));

    // R9: busy stays up until the encode state
    p_busy_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && state_q != S_FINISH) |=> busy_q);
endmodule

// File: tb/pll_param_search_test.sv
module pll_param_search_test;
    localparam longint unsigned REF = 64'd14318180;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] freq = '0;
    logic        busy, done, range_err;
    logic [7:0]  m_code, n_code, div_code;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit wd_hit = 0;
    int prev_m = 0, prev_n = 0, prev_d = 0;

    always #5 clk = ~clk;

    pll_param_search uut (
        .clk(clk), .rst_n(rst_n), .start(start), .freq_hz(freq),
        .busy(busy), .done(done), .range_err(range_err),
        .m_code(m_code), .n_code(n_code), .div_code(div_code)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000 && !wd_hit) begin
            wd_hit = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual=%0d cycles expected=<190000", cyc);
            $display("Result: errors=%0d of %0d checks", fails, checks);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string what, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    // independent model of the search
    function automatic void model(input longint unsigned f, output bit bad,
                                  output int mc, output int nc, output int dc, output int k);
        longint unsigned t, m, me, e, best_e, lhs, rhs;
        int best_m, best_n, d;
        bad = (f < 64'd3125000) || (f > 64'd220000000);
        mc = 0; nc = 0; dc = 0; k = 0;
        if (bad) return;
        t = f; d = 0;
        while (t < 64'd100000000) begin
            t = t << 1;
            d += 16;
            k++;
        end
        best_e = '1; best_m = 0; best_n = 0;
        for (int n = 3; n <= 257; n++) begin
            m = (longint'(n) * t) / REF;
            if (m <= 1028) begin
                me  = (m >= 3 && m <= 257) ? m : (m & ~64'd3);
                lhs = t * longint'(n);
                rhs = REF * me;
                e   = (lhs >= rhs) ? lhs - rhs : rhs - lhs;
                if (e < best_e) begin
                    best_e = e;
                    best_m = int'(m);
                    best_n = n;
                end
            end
        end
        nc = best_n - 2;
        if (best_m > 257) begin
            mc = (best_m >> 2) - 2;
            dc = d;
        end else begin
            mc = best_m - 2;
            dc = d | 4;
        end
    endfunction

    task automatic run_req(input logic [31:0] f, input bit poke, input logic [31:0] f2);
        int lat, mc, nc, dc, k;
        bit bad, seen;
        model(longint'(f), bad, mc, nc, dc, k);
        @(negedge clk);
        freq  = f;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat  = 0;
        seen = done;
        while (!seen && lat < 6000) begin
            if (poke && lat == 200) begin
                chk(busy == 1'b1, "R9 busy when second start arrives", busy, 1);
                freq  = f2;
                start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            lat++;
            seen = done;
        end
        start = 1'b0;
        chk(seen, "R8 done arrives", seen, 1);
        if (bad) begin
            chk(lat == 0, "R2 reject latency", lat, 0);
            chk(range_err == 1'b1, "R2 range_err", range_err, 1);
            chk(busy == 1'b0, "R2 busy low", busy, 0);
            chk(int'(m_code) == prev_m, "R2 m_code kept", m_code, prev_m);
            chk(int'(n_code) == prev_n, "R2 n_code kept", n_code, prev_n);
            chk(int'(div_code) == prev_d, "R2 div_code kept", div_code, prev_d);
        end else begin
            chk(lat == k + 1 + 255 * 15 + 1, "R8 search latency", lat, k + 3827);
            chk(range_err == 1'b0, "R8 range_err clear", range_err, 0);
            chk(int'(div_code[7:4]) == k, "R3 doubling count", div_code[7:4], k);
            chk(int'(n_code) == nc, "R4 R5 n_code", n_code, nc);
            chk(int'(m_code) == mc, "R5 R6 R7 m_code", m_code, mc);
            chk(int'(div_code) == dc, "R7 div_code", div_code, dc);
            prev_m = mc; prev_n = nc; prev_d = dc;
        end
        @(negedge clk);
        chk(done == 1'b0, "R8 done one cycle", done, 0);
        chk(busy == 1'b0, "R8 busy released", busy, 0);
    endtask

    initial begin
        logic [31:0] rf;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(busy == 1'b0, "R1 busy", busy, 0);
        chk(done == 1'b0, "R1 done", done, 0);
        chk(range_err == 1'b0, "R1 range_err", range_err, 0);
        chk(m_code == 8'd0 && n_code == 8'd0, "R1 m/n codes", {m_code, n_code}, 0);
        chk(div_code == 8'd0, "R1 div_code", div_code, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 band edges and just outside them
        run_req(32'd3124999, 0, 0);
        run_req(32'd3125000, 0, 0);
        run_req(32'd220000001, 0, 0);
        run_req(32'd220000000, 0, 0);
        run_req(32'd100000000, 0, 0);
        run_req(32'd99999999, 0, 0);
        run_req(32'd25175000, 0, 0);
        run_req(32'd0, 0, 0);
        // R9 second start mid-search with a different request
        run_req(32'd65000000, 1, 32'd40000000);
        // random in-band and occasional out-of-band requests
        for (int i = 0; i < 10; i++) begin
            if (i % 5 == 4) rf = 32'd220000000 + 32'd1 + ($urandom % 32'd1000000);
            else            rf = 32'd3125000 + ($urandom % 32'd216875001);
            run_req(rf, 0, 0);
        end

        $display("Result: errors=%0d of %0d checks", fails, checks);
        $finish;
    end
endmodule